// File: doc/BRIEF.md
# Pulse Duration Capture Receiver

This block watches a single input line and turns it into a list of timed spans. Each span is stored as a 16-bit entry that holds the span's level and its length, counted in ticks of a programmable clock divider. Two entries share one 32-bit word of a shared RAM, so a captured list has the same layout that a pulse player reads back. An optional glitch filter can drop short pulses before they are measured.

The capture is armed by raising an enable input. It begins at the first level change that follows. It ends in one of three ways. If the line stays quiet for a programmable number of ticks, a final span and a zero-length end marker are written and the block reports done. If the allocated RAM region fills, the block stops and raises an overflow flag. If the receiver does not own the RAM, the write is blocked and an ownership error is raised. The RAM region is chosen as a starting block and a block count, and it may run past the top of the RAM and wrap to address zero.

Top module: `rxcap_top`

## Requirements
- R1: The tick divider produces one tick every `div_val`+1 clocks, and every span length is a count of these ticks.
- R2: A rising edge on `cap_en` clears `done`, `own_err` and `ovf_err`. The capture then waits for the first level change of the (filtered) line. The level held before that change is not recorded.
- R3: An entry is 16 bits: bit 15 is the span's level and bits 14:0 are its length. The first entry goes to the low half of the word (`wr_be` = 4'b0011), the next to the high half (`wr_be` = 4'b1100), and the word address then steps up by one. The entry appears in the byte lanes that `wr_be` enables.
- R4: Each level change closes the running span. The entry written carries the span's level and the number of ticks that fell between the two changes.
- R5: With `filt_en` high, a level that lasts fewer than `filt_thr` clocks is ignored (a threshold of 0 acts as 1). Longer levels pass through with a fixed delay, so their measured lengths are unchanged.
- R6: When `idle_thr` ticks pass with no level change (0 acts as 1), the running span is written with length `idle_thr`. An entry {level, 0} follows in the next slot, and `done` rises.
- R7: When a span would pass 32767 ticks, an entry of length 32767 is written. A new span of the same level then continues counting.
- R8: The region starts at word `blk_base`*64 and covers `blk_cnt` blocks of 64 words (0 is taken as 1, and values above 8 are taken as 8). Word addresses wrap from 511 to 0.
- R9: If the last slot of the region is filled by an entry that is not an end marker, `ovf_err` and `done` rise and no further writes occur.
- R10: If an entry is due while `own_rx` is low, nothing is written, and `own_err` and `done` rise.
- R11: Dropping `cap_en` stops the capture and clears `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cap_en | input | 1 | Capture enable; its rising edge arms a new capture |
| div_val | input | 8 | Tick divider; tick period is div_val+1 clocks |
| filt_en | input | 1 | Enables the glitch filter |
| filt_thr | input | 8 | Minimum pulse width in clocks that the filter passes |
| idle_thr | input | 16 | Ticks without a level change that end the capture |
| blk_base | input | 3 | First 64-word block of the region |
| blk_cnt | input | 4 | Number of blocks in the region |
| own_rx | input | 1 | High when the receiver owns the RAM |
| rx_pin | input | 1 | Line being measured |
| wr_en | output | 1 | RAM write strobe |
| wr_addr | output | 9 | RAM word address |
| wr_data | output | 32 | Write data; the entry is placed in both halves |
| wr_be | output | 4 | Byte enables selecting the half written |
| done | output | 1 | Capture finished |
| own_err | output | 1 | A write was blocked by ownership |
| ovf_err | output | 1 | Region filled before the line went idle |

## Verification
The hardest case to reach from the ports is the 32767-tick rollover. It needs a span far longer than any normal pulse, and the idle limit must be set above the rollover point so that it does not end the span first. The bench sets the divider to 0, so every clock is a tick. It holds the line high for 33000 clocks and then low, with an idle limit of 40000. This gives a split span at each level and then a final length left over after the rollover. The overflow case starts the region in the top block and lets it wrap to address zero. A train of one-tick pulses fills all 256 slots.

// File: rtl/rxcap_pkg.sv
package rxcap_pkg;
    localparam int PER_W = 15;
    localparam logic [PER_W-1:0] PER_MAX = '1;

    typedef struct packed {
        logic             lvl;
        logic [PER_W-1:0] per;
    } entry_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_RUN,
        ST_END,
        ST_DONE
    } state_t;
endpackage

// File: rtl/rxcap_tick.sv
module rxcap_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_val,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = (cnt_q >= div_val);
        cnt_d = tick ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R1
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick && div_val != '0 |=> !tick || div_val != $past(div_val));
endmodule

// File: rtl/rxcap_filt.sv
module rxcap_filt #(
    parameter int FLT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             filt_en,
    input  logic [FLT_W-1:0] filt_thr,
    input  logic             pin,
    output logic             lvl
);
    typedef struct packed {
        logic             raw;
        logic             out;
        logic [FLT_W-1:0] cnt;
    } fst_t;

    fst_t d, q;

    always_comb begin
        d     = q;
        d.raw = pin;
        if (!filt_en) begin
            d.out = q.raw;
            d.cnt = '0;
        end else if (q.raw == q.out) begin
            d.cnt = '0;
        end else if ({1'b0, q.cnt} + 1'b1 >= {1'b0, filt_thr}) begin
            d.out = q.raw;
            d.cnt = '0;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign lvl = q.out;

    // R5
    filt_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.out) |-> $past(q.raw) == q.out);
endmodule

// File: rtl/rxcap_top.sv
module rxcap_top
    import rxcap_pkg::*;
#(
    parameter int DIV_W    = 8,
    parameter int FLT_W    = 8,
    parameter int IDLE_W   = 16,
    parameter int BLK_LOG  = 6,
    parameter int NBLK_LOG = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cap_en,
    input  logic [DIV_W-1:0]            div_val,
    input  logic                        filt_en,
    input  logic [FLT_W-1:0]            filt_thr,
    input  logic [IDLE_W-1:0]           idle_thr,
    input  logic [NBLK_LOG-1:0]         blk_base,
    input  logic [NBLK_LOG:0]           blk_cnt,
    input  logic                        own_rx,
    input  logic                        rx_pin,
    output logic                        wr_en,
    output logic [BLK_LOG+NBLK_LOG-1:0] wr_addr,
    output logic [31:0]                 wr_data,
    output logic [3:0]                  wr_be,
    output logic                        done,
    output logic                        own_err,
    output logic                        ovf_err
);
    localparam int AW   = BLK_LOG + NBLK_LOG;
    localparam int NBLK = 1 << NBLK_LOG;

    typedef struct packed {
        state_t            st;
        logic              en_prev;
        logic              lvl;
        logic [PER_W-1:0]  cnt;
        logic [IDLE_W-1:0] idl;
        logic [AW-1:0]     waddr;
        logic              hi;
        logic [AW:0]       used;
        logic              wr_en;
        logic [AW-1:0]     wr_addr;
        logic [31:0]       wr_data;
        logic [3:0]        wr_be;
        logic              done;
        logic              oerr;
        logic              verr;
    } rst_t;

    rst_t d, q;
    logic tick, filt;
    logic emit;
    entry_t ent;
    logic [NBLK_LOG:0] blocks;
    logic [AW:0]       last_word;
    logic [IDLE_W-1:0] thr_eff;
    logic              edge_seen;
    logic              idle_hit;

    rxcap_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .div_val(div_val), .tick(tick)
    );

    rxcap_filt #(.FLT_W(FLT_W)) u_filt (
        .clk(clk), .rst_n(rst_n), .filt_en(filt_en), .filt_thr(filt_thr),
        .pin(rx_pin), .lvl(filt)
    );

    always_comb begin
        if (blk_cnt == '0)                    blocks = 1;
        else if (blk_cnt > (NBLK_LOG+1)'(NBLK)) blocks = (NBLK_LOG+1)'(NBLK);
        else                                  blocks = blk_cnt;
        last_word = {blocks, {BLK_LOG{1'b0}}} - 1'b1;
        thr_eff   = (idle_thr == '0) ? IDLE_W'(1) : idle_thr;
        edge_seen = (filt != q.lvl);
        idle_hit  = ({1'b0, q.idl} + 1'b1) >= {1'b0, thr_eff};
    end

    always_comb begin
        d         = q;
        d.wr_en   = 1'b0;
        d.en_prev = cap_en;
        emit      = 1'b0;
        ent       = '0;

        unique case (q.st)
            ST_IDLE: if (cap_en && !q.en_prev) begin
                d.st    = ST_WAIT;
                d.lvl   = filt;
                d.waddr = {blk_base, {BLK_LOG{1'b0}}};
                d.hi    = 1'b0;
                d.used  = '0;
                d.done  = 1'b0;
                d.oerr  = 1'b0;
                d.verr  = 1'b0;
            end
            ST_WAIT: if (edge_seen) begin
                d.st  = ST_RUN;
                d.lvl = filt;
                d.cnt = PER_W'(tick);
                d.idl = IDLE_W'(tick);
            end
            ST_RUN: begin
                if (edge_seen) begin
                    emit  = 1'b1;
                    ent   = '{lvl: q.lvl, per: q.cnt};
                    d.lvl = filt;
                    d.cnt = PER_W'(tick);
                    d.idl = IDLE_W'(tick);
                end else if (tick) begin
                    if (q.idl != '1) d.idl = q.idl + 1'b1;
                    if (idle_hit) begin
                        emit = 1'b1;
                        ent  = '{lvl: q.lvl, per: (q.cnt == PER_MAX) ? PER_MAX : q.cnt + 1'b1};
                        d.st = ST_END;
                    end else if (q.cnt == PER_MAX) begin
                        emit  = 1'b1;
                        ent   = '{lvl: q.lvl, per: PER_MAX};
                        d.cnt = PER_W'(1);
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            ST_END: begin
                emit = 1'b1;
                ent  = '{lvl: q.lvl, per: '0};
            end
            default: ;
        endcase

        if (emit) begin
            if (!own_rx) begin
                d.oerr = 1'b1;
                d.done = 1'b1;
                d.st   = ST_DONE;
            end else begin
                d.wr_en   = 1'b1;
                d.wr_addr = q.waddr;
                d.wr_data = {ent, ent};
                d.wr_be   = q.hi ? 4'b1100 : 4'b0011;
                if (ent.per == '0) begin
                    d.done = 1'b1;
                    d.st   = ST_DONE;
                end else if (q.hi && q.used == last_word) begin
                    d.verr = 1'b1;
                    d.done = 1'b1;
                    d.st   = ST_DONE;
                end else if (q.hi) begin
                    d.hi    = 1'b0;
                    d.waddr = q.waddr + 1'b1;
                    d.used  = q.used + 1'b1;
                end else begin
                    d.hi = 1'b1;
                end
            end
        end

        if (!cap_en) begin
            d.st    = ST_IDLE;
            d.done  = 1'b0;
            d.wr_en = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, default: '0};
        else        q <= d;
    end

    assign wr_en   = q.wr_en;
    assign wr_addr = q.wr_addr;
    assign wr_data = q.wr_data;
    assign wr_be   = q.wr_be;
    assign done    = q.done;
    assign own_err = q.oerr;
    assign ovf_err = q.verr;

    logic [15:0] wr_half;
    assign wr_half = wr_be[2] ? wr_data[31:16] : wr_data[15:0];

    // R3
    be_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_be == 4'b0011 || wr_be == 4'b1100));
    // R10
    own_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(own_rx));
    // R6
    marker_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_half[14:0] == '0 |-> done);
    // R9
    quiet_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && $past(done) |-> !wr_en);
    // R11
    en_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cap_en) |-> !done && !wr_en);
endmodule

// File: tb/tb_rxcap_top.sv
module tb_rxcap_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cap_en = 1'b0;
    logic [7:0]  div_val = 8'd3;
    logic        filt_en = 1'b0;
    logic [7:0]  filt_thr = 8'd0;
    logic [15:0] idle_thr = 16'd20;
    logic [2:0]  blk_base = 3'd0;
    logic [3:0]  blk_cnt = 4'd1;
    logic        own_rx = 1'b1;
    logic        rx_pin = 1'b0;
    logic        wr_en;
    logic [8:0]  wr_addr;
    logic [31:0] wr_data;
    logic [3:0]  wr_be;
    logic        done, own_err, ovf_err;

    int checks = 0;
    int fails = 0;
    int nw = 0;
    int log_addr [0:511];
    int log_be   [0:511];
    int log_ent  [0:511];

    always #4 clk = ~clk;

    rxcap_top dut (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .div_val(div_val),
        .filt_en(filt_en), .filt_thr(filt_thr), .idle_thr(idle_thr),
        .blk_base(blk_base), .blk_cnt(blk_cnt), .own_rx(own_rx), .rx_pin(rx_pin),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
        .done(done), .own_err(own_err), .ovf_err(ovf_err)
    );

    always @(negedge clk) begin
        if (rst_n && wr_en && nw < 512) begin
            log_addr[nw] = int'(wr_addr);
            log_be[nw]   = int'(wr_be);
            log_ent[nw]  = (wr_be == 4'b1100) ? int'(wr_data[31:16]) : int'(wr_data[15:0]);
            nw = nw + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic hold(input logic v, input int n);
        rx_pin = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic start_cap();
        @(negedge clk);
        cap_en = 1'b0;
        repeat (2) @(negedge clk);
        nw = 0;
        cap_en = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic wait_done(input int maxc, input string req);
        int n = 0;
        while (!done && n < maxc) begin
            @(negedge clk);
            n++;
        end
        chk(done == 1'b1, req, "done reached", int'(done), 1);
        repeat (4) @(negedge clk);
    endtask

    task automatic exp_entry(input int i, input int addr, input bit hi, input int val, input string req);
        chk(log_addr[i] == addr, req, $sformatf("entry %0d addr", i), log_addr[i], addr);
        chk(log_be[i] == (hi ? 12 : 3), req, $sformatf("entry %0d be", i), log_be[i], hi ? 12 : 3);
        chk(log_ent[i] == val, req, $sformatf("entry %0d value", i), log_ent[i], val);
    endtask

    task automatic t_reset();
        chk(wr_en == 1'b0, "R2", "reset wr_en", int'(wr_en), 0);
        chk(done == 1'b0, "R2", "reset done", int'(done), 0);
        chk(own_err == 1'b0 && ovf_err == 1'b0, "R2", "reset flags", int'({own_err, ovf_err}), 0);
    endtask

    task automatic t_owner();
        own_rx = 1'b0; div_val = 8'd3; idle_thr = 16'd20; blk_base = 3'd0; blk_cnt = 4'd1;
        rx_pin = 1'b0;
        start_cap();
        hold(1'b0, 8); hold(1'b1, 8); hold(1'b0, 8);
        wait_done(200, "R10");
        chk(own_err == 1'b1, "R10", "own_err", int'(own_err), 1);
        chk(nw == 0, "R10", "blocked writes", nw, 0);
        cap_en = 1'b0;
        repeat (2) @(negedge clk);
        chk(done == 1'b0, "R11", "done after disable", int'(done), 0);
        own_rx = 1'b1;
    endtask

    task automatic t_basic();
        div_val = 8'd3; filt_en = 1'b0; idle_thr = 16'd20; blk_base = 3'd0; blk_cnt = 4'd1;
        rx_pin = 1'b0;
        start_cap();
        chk(own_err == 1'b0 && done == 1'b0, "R2", "flags cleared on start", int'({own_err, done}), 0);
        hold(1'b0, 8); hold(1'b1, 20); hold(1'b0, 12); hold(1'b1, 28); rx_pin = 1'b0;
        wait_done(400, "R6");
        chk(nw == 5, "R4", "entry count", nw, 5);
        exp_entry(0, 0, 1'b0, 16'h8005, "R4");
        exp_entry(1, 0, 1'b1, 16'h0003, "R3");
        exp_entry(2, 1, 1'b0, 16'h8007, "R1");
        exp_entry(3, 1, 1'b1, 16'h0014, "R6");
        exp_entry(4, 2, 1'b0, 16'h0000, "R6");
    endtask

    task automatic t_filter();
        div_val = 8'd3; filt_en = 1'b1; filt_thr = 8'd6; idle_thr = 16'd10;
        blk_base = 3'd1; blk_cnt = 4'd0;
        rx_pin = 1'b0;
        start_cap();
        hold(1'b0, 8); hold(1'b1, 12); hold(1'b0, 3); hold(1'b1, 13); rx_pin = 1'b0;
        wait_done(400, "R5");
        chk(nw == 3, "R5", "entry count with glitch", nw, 3);
        exp_entry(0, 64, 1'b0, 16'h8007, "R5");
        exp_entry(1, 64, 1'b1, 16'h000A, "R5");
        exp_entry(2, 65, 1'b0, 16'h0000, "R8");
        filt_en = 1'b0;
    endtask

    task automatic t_overflow();
        int bad = 0;
        div_val = 8'd3; idle_thr = 16'd10; blk_base = 3'd7; blk_cnt = 4'd2;
        rx_pin = 1'b0;
        start_cap();
        hold(1'b0, 8);
        for (int k = 0; k < 300; k++) hold(k[0] ? 1'b0 : 1'b1, 4);
        chk(ovf_err == 1'b1, "R9", "ovf_err", int'(ovf_err), 1);
        chk(done == 1'b1, "R9", "done on overflow", int'(done), 1);
        chk(nw == 256, "R9", "writes before overflow", nw, 256);
        for (int i = 0; i < 256; i++) begin
            if (log_addr[i] != ((448 + i / 2) % 512)) bad++;
            if (log_be[i] != ((i % 2) ? 12 : 3)) bad++;
            if (log_ent[i] != ((i % 2) ? 16'h0001 : 16'h8001)) bad++;
        end
        chk(bad == 0, "R8", "wrapped region layout mismatches", bad, 0);
        chk(log_addr[255] == 63, "R8", "last word after wrap", log_addr[255], 63);
    endtask

    task automatic t_rollover();
        div_val = 8'd0; idle_thr = 16'd40000; blk_base = 3'd2; blk_cnt = 4'd1;
        rx_pin = 1'b0;
        start_cap();
        hold(1'b0, 8); hold(1'b1, 33000); rx_pin = 1'b0;
        wait_done(50000, "R7");
        chk(nw == 5, "R7", "entry count", nw, 5);
        exp_entry(0, 128, 1'b0, 16'hFFFF, "R7");
        exp_entry(1, 128, 1'b1, 16'h80E9, "R7");
        exp_entry(2, 129, 1'b0, 16'h7FFF, "R7");
        exp_entry(3, 129, 1'b1, 16'h1C41, "R6");
        exp_entry(4, 130, 1'b0, 16'h0000, "R6");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_owner();
        t_basic();
        t_filter();
        t_overflow();
        t_rollover();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule